// File: doc/BRIEF.md
# Memory protection configuration register bank

This block is the privileged register bank that software uses to program a memory protection unit with up to sixteen regions. One small register bus (an index, read and write strobes, write data and a user-mode qualifier) reaches a build register, an enable register, a violation cause register, and a base and permission descriptor for each region. The bank packs and unpacks the field layouts and flags illegal accesses on two separate error outputs.

The decoded state of every region is exported to a separate address checker. For each region it gives the base address, the valid flag, the six permission bits and an address mask derived from the region's size code. It also exports the default-region permissions and an active flag. The checker reports violations back through a cause-load port. A machine-check input turns the unit off without touching the stored enable bit.

Top module: `mpu_cfg_regs`

## Requirements
- R1: After reset the unit is disabled and inactive, and every permission bit is clear. Every base is invalid with address 0, every size code is 0 and every region mask is all ones. Read data and both error flags are 0.
- R2: The enable register (index 1) holds the global enable at bit 30. It holds the default permissions at bits 8..3: bit 8 kernel read, bit 7 kernel write, bit 6 kernel execute, bit 5 user read, bit 4 user write, bit 3 user execute. All other bits read as zero.
- R3: The base register of region r (index 16+r) holds the address in bits 31..5 and the valid flag in bit 0. Bits 4..1 read as zero, and the exported base has its low five bits at zero.
- R4: The permission register of region r (index 32+r) holds the size code split in two parts: code bits 1..0 at bits 1..0 and code bits 4..2 at bits 11..9. The six permission bits sit at bits 8..3 in the R2 order. All other bits read as zero.
- R5: A size code n from 4 to 30 gives the region mask ~((2<<n)-1). A code of 31 gives a mask of 0. A code below 4 gives a mask of all ones.
- R6: The build register (index 0) reads (NUM_RGN << 8) | 0x03. When the unit is configured absent, every access raises the instruction-error flag and reads zero.
- R7: The cause register (index 2) reads (0x06 << 16) | (type << 8) | region. It is loaded by the cause-load strobe, which carries a 2-bit type and an 8-bit region number.
- R8: Any access with user mode high raises the privilege error, not the instruction error. It reads zero and changes no register.
- R9: In kernel mode, the following raise the instruction-error flag: a descriptor index whose region is at or above NUM_RGN, and an index outside 0..2, 16..31 and 32..47. Such an access reads zero and changes no register.
- R10: A legal enable write sets the active flag to bit 30 of the write data. The machine-check input clears the active flag and leaves the enable bit readable as before, and it wins over a same-cycle enable write.
- R11: Read data and error flags are registered and valid in the cycle after the access. In a cycle with no read, the read data is zero, and the error flags are high only in the cycle after a faulting access.
- R12: Writes to the build and cause registers are ignored without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 6 | Register index |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| user_mode | input | 1 | Access is made from user mode |
| mchk | input | 1 | Machine check, clears the active flag |
| cause_ld | input | 1 | Load the cause register |
| cause_type | input | 2 | Violation type to record |
| cause_rgn | input | 8 | Region number to record |
| reg_rdata | output | 32 | Registered read data |
| err_priv | output | 1 | Privilege violation flag |
| err_instr | output | 1 | Instruction error flag |
| mpu_active | output | 1 | Protection is in force |
| def_perm | output | 6 | Default-region permissions, R2 order |
| rgn_valid | output | 16 | Valid flag per region |
| rgn_base | output | 512 | Base address per region, 32 bits each |
| rgn_mask | output | 512 | Address mask per region, 32 bits each |
| rgn_perm | output | 96 | Permissions per region, 6 bits each |

## Verification
The hardest state to reach is the machine-check case. After it, the active flag is low while the enable bit still reads back as set, and only a following read of the enable register shows that the two have split. The bench raises the machine check after a legal enable write and then reads the register. It also covers the case where the machine check and an enable write land in the same cycle. Size codes are written so that their high part at bits 11..9 is non-zero, and a bench with only four regions makes in-range indices fault, so the count check is covered.

// File: rtl/mpu_cfg_pkg.sv
package mpu_cfg_pkg;
  localparam int          MAX_RGN   = 16;
  localparam logic [7:0]  MPU_VER   = 8'h03;
  localparam logic [7:0]  CAUSE_VEC = 8'h06;

  typedef struct packed {
    logic kr;
    logic kw;
    logic ke;
    logic ur;
    logic uw;
    logic ue;
  } perm_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BUILD,
    SEL_EN,
    SEL_CAUSE,
    SEL_BASE,
    SEL_PERM
  } sel_e;

  function automatic logic [31:0] code_to_mask(input logic [4:0] code);
    logic [32:0] span;
    span = (33'd2 << code) - 33'd1;
    if (code < 5'd4) return '1;
    return ~span[31:0];
  endfunction
endpackage

// File: rtl/mpu_cfg_decode.sv
module mpu_cfg_decode
  import mpu_cfg_pkg::*;
#(
  parameter int NUM_RGN = 16,
  parameter bit PRESENT = 1'b1
) (
  input  logic [5:0] reg_idx,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic       user_mode,
  output sel_e       sel,
  output logic [3:0] rgn,
  output logic       rd_ok,
  output logic       wr_ok,
  output logic       fault_priv,
  output logic       fault_instr
);
  logic access;
  logic in_range;

  always_comb begin
    sel = SEL_NONE;
    if (reg_idx == 6'd0)            sel = SEL_BUILD;
    else if (reg_idx == 6'd1)       sel = SEL_EN;
    else if (reg_idx == 6'd2)       sel = SEL_CAUSE;
    else if (reg_idx[5:4] == 2'b01) sel = SEL_BASE;
    else if (reg_idx[5:4] == 2'b10) sel = SEL_PERM;
  end

  assign rgn      = reg_idx[3:0];
  assign in_range = ({1'b0, rgn} < 5'(NUM_RGN));
  assign access   = reg_rd | reg_wr;

  always_comb begin
    fault_priv  = access & user_mode;
    fault_instr = 1'b0;
    if (access && !user_mode) begin
      if (!PRESENT || sel == SEL_NONE)
        fault_instr = 1'b1;
      else if ((sel == SEL_BASE || sel == SEL_PERM) && !in_range)
        fault_instr = 1'b1;
    end
  end

  assign rd_ok = reg_rd & ~fault_priv & ~fault_instr;
  assign wr_ok = reg_wr & ~fault_priv & ~fault_instr;
endmodule

// File: rtl/mpu_rgn_desc.sv
module mpu_rgn_desc
  import mpu_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_we,
  input  logic        perm_we,
  input  logic [31:0] wdata,
  output logic [31:0] base_o,
  output logic        valid_o,
  output perm_t       perm_o,
  output logic [4:0]  code_o,
  output logic [31:0] mask_o,
  output logic [31:0] rd_base,
  output logic [31:0] rd_perm
);
  logic [26:0] addr_q, addr_d;
  logic        val_q, val_d;
  logic [4:0]  code_q, code_d;
  perm_t       perm_q, perm_d;
  logic        unused_bit2;

  assign unused_bit2 = wdata[2];

  always_comb begin
    addr_d = addr_q;
    val_d  = val_q;
    code_d = code_q;
    perm_d = perm_q;
    if (base_we) begin
      addr_d = wdata[31:5];
      val_d  = wdata[0];
    end
    if (perm_we) begin
      code_d = {wdata[11:9], wdata[1:0]};
      perm_d = perm_t'(wdata[8:3]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      val_q  <= 1'b0;
      code_q <= '0;
      perm_q <= '0;
    end else begin
      addr_q <= addr_d;
      val_q  <= val_d;
      code_q <= code_d;
      perm_q <= perm_d;
    end
  end

  assign base_o  = {addr_q, 5'b0};
  assign valid_o = val_q;
  assign perm_o  = perm_q;
  assign code_o  = code_q;
  assign mask_o  = code_to_mask(code_q);
  assign rd_base = {addr_q, 4'b0, val_q};
  assign rd_perm = {20'b0, code_q[4:2], perm_q, 1'b0, code_q[1:0]};

  // R4: the stored size code is the two split fields of the last write
  p_code_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    perm_we |=> code_o == {$past(wdata[11:9]), $past(wdata[1:0])});
endmodule

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
  import mpu_cfg_pkg::*;
#(
  parameter int NUM_RGN = 16,
  parameter bit PRESENT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [5:0]            reg_idx,
  input  logic                  reg_rd,
  input  logic                  reg_wr,
  input  logic [31:0]           reg_wdata,
  input  logic                  user_mode,
  input  logic                  mchk,
  input  logic                  cause_ld,
  input  logic [1:0]            cause_type,
  input  logic [7:0]            cause_rgn,
  output logic [31:0]           reg_rdata,
  output logic                  err_priv,
  output logic                  err_instr,
  output logic                  mpu_active,
  output logic [5:0]            def_perm,
  output logic [MAX_RGN-1:0]    rgn_valid,
  output logic [MAX_RGN*32-1:0] rgn_base,
  output logic [MAX_RGN*32-1:0] rgn_mask,
  output logic [MAX_RGN*6-1:0]  rgn_perm
);
  localparam logic [7:0] CNT_FIELD = PRESENT ? 8'(NUM_RGN) : 8'd0;
  localparam logic [7:0] VER_FIELD = PRESENT ? MPU_VER : 8'd0;

  sel_e        sel;
  logic [3:0]  rgn;
  logic        rd_ok, wr_ok, fault_priv, fault_instr;

  logic        en_q, en_d, act_q, act_d;
  perm_t       dperm_q, dperm_d;
  logic [1:0]  ctype_q, ctype_d;
  logic [7:0]  creg_q, creg_d;
  logic [31:0] rdata_q, rdata_d, rd_val;
  logic        errp_q, erri_q;

  logic [31:0] rd_base [MAX_RGN];
  logic [31:0] rd_perm [MAX_RGN];

  mpu_cfg_decode #(.NUM_RGN(NUM_RGN), .PRESENT(PRESENT)) u_dec (
    .reg_idx    (reg_idx),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .user_mode  (user_mode),
    .sel        (sel),
    .rgn        (rgn),
    .rd_ok      (rd_ok),
    .wr_ok      (wr_ok),
    .fault_priv (fault_priv),
    .fault_instr(fault_instr)
  );

  for (genvar r = 0; r < MAX_RGN; r++) begin : g_rgn
    if (r < NUM_RGN) begin : g_live
      logic       base_we, perm_we;
      perm_t      perm_w;
      logic [4:0] code_w;
      logic       unused_code;
      assign base_we     = wr_ok && sel == SEL_BASE && rgn == 4'(r);
      assign perm_we     = wr_ok && sel == SEL_PERM && rgn == 4'(r);
      assign unused_code = ^code_w;
      mpu_rgn_desc u_desc (
        .clk    (clk),
        .rst_n  (rst_n),
        .base_we(base_we),
        .perm_we(perm_we),
        .wdata  (reg_wdata),
        .base_o (rgn_base[r*32 +: 32]),
        .valid_o(rgn_valid[r]),
        .perm_o (perm_w),
        .code_o (code_w),
        .mask_o (rgn_mask[r*32 +: 32]),
        .rd_base(rd_base[r]),
        .rd_perm(rd_perm[r])
      );
      assign rgn_perm[r*6 +: 6] = perm_w;
    end else begin : g_tie
      assign rgn_base[r*32 +: 32] = '0;
      assign rgn_valid[r]         = 1'b0;
      assign rgn_perm[r*6 +: 6]   = '0;
      assign rgn_mask[r*32 +: 32] = '1;
      assign rd_base[r]           = '0;
      assign rd_perm[r]           = '0;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_BUILD: rd_val = {16'b0, CNT_FIELD, VER_FIELD};
      SEL_EN:    rd_val = {1'b0, en_q, 21'b0, dperm_q, 3'b0};
      SEL_CAUSE: rd_val = {8'b0, CAUSE_VEC, 6'b0, ctype_q, creg_q};
      SEL_BASE:  rd_val = rd_base[rgn];
      SEL_PERM:  rd_val = rd_perm[rgn];
      default:   rd_val = '0;
    endcase
  end

  always_comb begin
    en_d    = en_q;
    act_d   = act_q;
    dperm_d = dperm_q;
    ctype_d = ctype_q;
    creg_d  = creg_q;
    if (wr_ok && sel == SEL_EN) begin
      en_d    = reg_wdata[30];
      act_d   = reg_wdata[30];
      dperm_d = perm_t'(reg_wdata[8:3]);
    end
    if (mchk) act_d = 1'b0;
    if (cause_ld) begin
      ctype_d = cause_type;
      creg_d  = cause_rgn;
    end
    rdata_d = rd_ok ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      act_q   <= 1'b0;
      dperm_q <= '0;
      ctype_q <= '0;
      creg_q  <= '0;
      rdata_q <= '0;
      errp_q  <= 1'b0;
      erri_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      act_q   <= act_d;
      dperm_q <= dperm_d;
      ctype_q <= ctype_d;
      creg_q  <= creg_d;
      rdata_q <= rdata_d;
      errp_q  <= fault_priv;
      erri_q  <= fault_instr;
    end
  end

  assign reg_rdata  = rdata_q;
  assign err_priv   = errp_q;
  assign err_instr  = erri_q;
  assign mpu_active = act_q;
  assign def_perm   = dperm_q;

  // R8: a user-mode write leaves the enable state untouched
  p_user_write_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && user_mode) |=> $stable(en_q) && $stable(dperm_q));
  // R9: a faulting access returns zero data
  p_fault_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_priv || err_instr) |-> reg_rdata == 32'd0);
  // R10: machine check always leaves the unit inactive
  p_mchk_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mchk |=> !mpu_active);
  // R10: the unit is never active while the stored enable is clear
  p_active_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mpu_active |-> en_q);
  // R11: no read strobe means zero read data next cycle
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == 32'd0);
endmodule

// File: tb/mpu_cfg_regs_test.sv
module mpu_cfg_regs_test;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_idx = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0, user_mode = 1'b0, mchk = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        cause_ld = 1'b0;
  logic [1:0]  cause_type = '0;
  logic [7:0]  cause_rgn = '0;

  logic [31:0]  reg_rdata, a_rdata;
  logic         err_priv, err_instr, mpu_active, a_ep, a_ei, a_act;
  logic [5:0]   def_perm, a_dp;
  logic [15:0]  rgn_valid, a_val;
  logic [511:0] rgn_base, rgn_mask, a_base, a_mask;
  logic [95:0]  rgn_perm, a_perm;

  always #4 clk = ~clk;

  mpu_cfg_regs #(.NUM_RGN(NR), .PRESENT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .user_mode(user_mode), .mchk(mchk), .cause_ld(cause_ld),
    .cause_type(cause_type), .cause_rgn(cause_rgn), .reg_rdata(reg_rdata),
    .err_priv(err_priv), .err_instr(err_instr), .mpu_active(mpu_active),
    .def_perm(def_perm), .rgn_valid(rgn_valid), .rgn_base(rgn_base),
    .rgn_mask(rgn_mask), .rgn_perm(rgn_perm));

  mpu_cfg_regs #(.NUM_RGN(NR), .PRESENT(1'b0)) uut_absent (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .user_mode(user_mode), .mchk(mchk), .cause_ld(cause_ld),
    .cause_type(cause_type), .cause_rgn(cause_rgn), .reg_rdata(a_rdata),
    .err_priv(a_ep), .err_instr(a_ei), .mpu_active(a_act),
    .def_perm(a_dp), .rgn_valid(a_val), .rgn_base(a_base),
    .rgn_mask(a_mask), .rgn_perm(a_perm));

  // reference model state
  bit          m_en, m_act;
  bit [5:0]    m_dp;
  bit [26:0]   m_addr [16];
  bit          m_val [16];
  bit [4:0]    m_code [16];
  bit [5:0]    m_perm [16];
  bit [1:0]    m_ct;
  bit [7:0]    m_cr;
  bit [31:0]   e_rdata;
  bit          e_ep, e_ei;
  string       e_tag = "R1";
  bit          absent_chk = 0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_mask(input int c);
    longint sz;
    if (c < 4) return 32'hFFFF_FFFF;
    sz = longint'(1) << (c + 1);
    return 32'(~(sz - 1));
  endfunction

  always @(negedge clk) begin
    chk(e_tag, reg_rdata, e_rdata);
    chk("R8", {31'b0, err_priv}, {31'b0, e_ep});
    chk("R9", {31'b0, err_instr}, {31'b0, e_ei});
    chk("R10", {31'b0, mpu_active}, {31'b0, m_act});
    chk("R2", {26'b0, def_perm}, {26'b0, m_dp});
    for (int r = 0; r < 16; r++) begin
      chk("R3", rgn_base[r*32 +: 32], {m_addr[r], 5'b0});
      chk("R3", {31'b0, rgn_valid[r]}, {31'b0, m_val[r]});
      chk("R4", {26'b0, rgn_perm[r*6 +: 6]}, {26'b0, m_perm[r]});
      chk("R5", rgn_mask[r*32 +: 32], exp_mask(int'(m_code[r])));
    end
    if (absent_chk) begin
      chk("R6", a_rdata, 32'd0);
      chk("R6", {31'b0, a_ei}, 32'd1);
      absent_chk = 0;
    end
  end

  // one clock of stimulus plus the model's view of it
  task automatic cyc(input bit rd, input bit wr, input int idx, input logic [31:0] wd,
                     input bit usr, input bit mc, input bit cl, input bit [1:0] ct,
                     input bit [7:0] cr, input string tag);
    bit ep, ei, bad_idx;
    bit [31:0] val;
    int r;
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_idx = 6'(idx); reg_wdata = wd; user_mode = usr;
    mchk = mc; cause_ld = cl; cause_type = ct; cause_rgn = cr;
    ep = (rd || wr) && usr;
    if (idx <= 2) bad_idx = 0;
    else if (idx >= 16 && idx < 32) bad_idx = (idx - 16) >= NR;
    else if (idx >= 32 && idx < 48) bad_idx = (idx - 32) >= NR;
    else bad_idx = 1;
    ei = (rd || wr) && !usr && bad_idx;
    r = idx % 16;
    val = 0;
    if (idx == 0) val = (NR << 8) | 3;
    else if (idx == 1) val = (32'(m_en) << 30) | (32'(m_dp) << 3);
    else if (idx == 2) val = (32'h6 << 16) | (32'(m_ct) << 8) | 32'(m_cr);
    else if (idx >= 16 && idx < 32) val = {m_addr[r], 5'b0} | 32'(m_val[r]);
    else if (idx >= 32 && idx < 48)
      val = (32'(m_code[r] >> 2) << 9) | (32'(m_perm[r]) << 3) | 32'(m_code[r] & 5'd3);
    @(posedge clk);
    #1;
    e_ep = ep; e_ei = ei;
    e_rdata = (rd && !ep && !ei) ? val : 32'd0;
    e_tag = rd ? tag : "R11";
    if (wr && !ep && !ei) begin
      if (idx == 1) begin m_en = wd[30]; m_act = wd[30]; m_dp = wd[8:3]; end
      else if (idx >= 16 && idx < 32) begin m_addr[r] = wd[31:5]; m_val[r] = wd[0]; end
      else if (idx >= 32 && idx < 48) begin
        m_code[r] = {wd[11:9], wd[1:0]}; m_perm[r] = wd[8:3];
      end
    end
    if (mc) m_act = 0;
    if (cl) begin m_ct = ct; m_cr = cr; end
  endtask

  task automatic rd_k(input int idx, input string tag);
    cyc(1, 0, idx, 32'h0, 0, 0, 0, 2'd0, 8'd0, tag);
  endtask
  task automatic wr_k(input int idx, input logic [31:0] wd, input string tag);
    cyc(0, 1, idx, wd, 0, 0, 0, 2'd0, 8'd0, tag);
  endtask
  task automatic idle();
    cyc(0, 0, 0, 32'h0, 0, 0, 0, 2'd0, 8'd0, "R11");
  endtask

  initial begin
    for (int r = 0; r < 16; r++) begin m_addr[r] = 0; m_val[r] = 0; m_code[r] = 0; m_perm[r] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(); idle();
    // R1: read back reset contents
    rd_k(1, "R1"); rd_k(16, "R1"); rd_k(35, "R1"); rd_k(2, "R1");
    // R6: build register, and the absent configuration
    rd_k(0, "R6");
    absent_chk = 1;
    idle();
    // R2: enable register packing
    wr_k(1, 32'hFFFF_FFFF, "R2"); rd_k(1, "R2");
    wr_k(1, 32'h4000_0120, "R2"); rd_k(1, "R2");
    // R3: base registers
    wr_k(16, 32'h1234_5677, "R3"); rd_k(16, "R3");
    wr_k(19, 32'h8000_001E, "R3"); rd_k(19, "R3");
    // R4 / R5: size code split and masks
    wr_k(32, 32'hFFFF_FFFF, "R4"); rd_k(32, "R4");
    wr_k(33, 32'h0000_0200, "R5"); rd_k(33, "R5");
    wr_k(34, 32'h0000_0402, "R5"); rd_k(34, "R5");
    wr_k(35, 32'h0000_0052, "R5"); rd_k(35, "R5");
    wr_k(34, 32'h0000_0D53, "R5"); rd_k(34, "R5");
    // R8: user mode accesses
    cyc(1, 0, 1, 32'h0, 1, 0, 0, 2'd0, 8'd0, "R8");
    cyc(0, 1, 1, 32'h0, 1, 0, 0, 2'd0, 8'd0, "R8");
    cyc(0, 1, 17, 32'hFFFF_FFE1, 1, 0, 0, 2'd0, 8'd0, "R8");
    rd_k(1, "R8"); rd_k(17, "R8");
    // R9: out-of-count and unmapped indices
    rd_k(21, "R9"); wr_k(39, 32'hFFFF_FFFF, "R9"); rd_k(5, "R9");
    wr_k(50, 32'hFFFF_FFFF, "R9"); rd_k(31, "R9"); rd_k(63, "R9");
    rd_k(35, "R9");
    // R12: read-only registers
    wr_k(0, 32'hDEAD_BEEF, "R12"); rd_k(0, "R12");
    wr_k(2, 32'hDEAD_BEEF, "R12"); rd_k(2, "R12");
    // R7: cause register loads
    cyc(0, 0, 0, 32'h0, 0, 0, 1, 2'd2, 8'd3, "R7"); rd_k(2, "R7");
    cyc(0, 0, 0, 32'h0, 0, 0, 1, 2'd3, 8'hFF, "R7"); rd_k(2, "R7");
    // R10: machine check
    wr_k(1, 32'h4000_0008, "R10");
    cyc(0, 0, 0, 32'h0, 0, 1, 0, 2'd0, 8'd0, "R10");
    rd_k(1, "R10");
    wr_k(1, 32'h0, "R10"); wr_k(1, 32'h4000_0000, "R10");
    cyc(0, 1, 1, 32'h4000_0010, 0, 1, 0, 2'd0, 8'd0, "R10");
    rd_k(1, "R10");
    // R11: back-to-back mixed accesses
    rd_k(16, "R11"); rd_k(22, "R11"); rd_k(0, "R11");
    cyc(1, 0, 0, 32'h0, 1, 0, 0, 2'd0, 8'd0, "R11");
    idle(); idle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule